// File: doc/BRIEF.md
# Operand Address Resolver for an 8-bit Accumulator Core

This block works out where the operand of an 8-bit accumulator-style processor lives and then fetches it. A request carries a 4-bit addressing-mode code, the instruction's two operand bytes, the X and Y index registers and the accumulator. The resolver either returns a value that needs no memory address, or it forms a 16-bit effective address and reads the byte stored there. It may chase a pointer through memory first. All reads go through a single byte-wide request/valid port into a 64K-byte space.

There are two pointer-chasing modes, and they wrap in different ways. Pre-indexed indirect builds its pointer location inside page zero, and both pointer bytes stay there, so a pointer at 0xFF takes its high byte from 0x00. Post-indexed indirect reads its pointer the same way, but then adds Y across the full 16 bits. Absolute-indirect reads its pointer word from a full 16-bit address, and the high byte carries into the next page. Each accepted request ends with a single done pulse. Until that pulse, further requests are ignored.

Top module: `ea_resolver`

## Requirements
- R1: Mode codes 0 (immediate, operand = first operand byte), 10 (accumulator), 11 (X) and 12 (Y) return that value with noAddr=1 and make no memory read.
- R2: Mode codes 1 (zero-page), 2 (zero-page + X) and 3 (zero-page + Y) give an address whose high byte is 0x00. The low byte is the first operand byte plus the index, truncated to 8 bits.
- R3: Mode code 4 (absolute) gives the little-endian word {second byte, first byte}. Codes 5 and 6 add the zero-extended X or Y to that word in 16-bit arithmetic, wrapping past 0xFFFF.
- R4: Mode code 7 (pre-indexed indirect) reads a little-endian pointer from zero-page location (first byte + X) mod 256. A pointer at 0xFF takes its high byte from 0x00.
- R5: Mode code 8 (post-indexed indirect) reads a little-endian pointer from the zero-page location named by the first byte, with the same 0xFF to 0x00 wrap. It then adds Y to the pointer as a 16-bit sum.
- R6: Mode code 9 (absolute-indirect) reads its low pointer byte at {second byte, first byte} and its high pointer byte at that address + 1 in 16-bit arithmetic. The pointer is the result.
- R7: For the address modes (codes 1 to 9), operand is the byte read at effAddr, noAddr=0 and err=0. Direct modes make exactly one read; pointer modes make exactly three.
- R8: Mode codes 13, 14 and 15 finish with err=1, noAddr=1 and no memory read.
- R9: Each accepted request yields done high for exactly one cycle. reqValid is ignored from acceptance until done has been seen.
- R10: Once memReq rises, it stays high with memAddr unchanged until a cycle with memRdValid high.
- R11: After reset, done and memReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a resolution (taken only when idle) |
| mode | input | 4 | Addressing-mode code |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte |
| idxX | input | 8 | X index register |
| idxY | input | 8 | Y index register |
| accIn | input | 8 | Accumulator value |
| memReq | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memRdValid | input | 1 | Read data valid; completes the current read |
| memRdData | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| noAddr | output | 1 | Result is a value with no memory address |
| err | output | 1 | Unused mode code |
| effAddr | output | 16 | Resolved effective address |
| operand | output | 8 | Resolved operand byte |

## Verification
The bench builds the resolver with the default 8-bit data width, which makes the address space 16 bits. Page-zero wrap, the 0xFF pointer wrap, a page carry in the absolute-indirect pointer and a 16-bit rollover past 0xFFFF can therefore all be reached with small operand constants. The bench's memory model holds each read for two extra wait cycles. That exercises the hold of the request, and it leaves a window in which a second request can be shown to be ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_IMM  = 4'd0,
    MD_ZPG  = 4'd1,
    MD_ZPX  = 4'd2,
    MD_ZPY  = 4'd3,
    MD_ABS  = 4'd4,
    MD_ABX  = 4'd5,
    MD_ABY  = 4'd6,
    MD_PREX = 4'd7,
    MD_POSY = 4'd8,
    MD_IND  = 4'd9,
    MD_ACC  = 4'd10,
    MD_REGX = 4'd11,
    MD_REGY = 4'd12,
    MD_RS13 = 4'd13,
    MD_RS14 = 4'd14,
    MD_RS15 = 4'd15
  } eaMode_e;

  typedef enum logic [1:0] {
    CL_VALUE,
    CL_DIRECT,
    CL_POINTER,
    CL_BAD
  } modeClass_e;

  typedef enum logic [1:0] {
    AS_PTR_LO,
    AS_PTR_HI,
    AS_EA
  } addrSel_e;

  typedef struct packed {
    logic     ldReq;
    logic     ldPtrLo;
    logic     ldPtrHi;
    logic     ldData;
    addrSel_e addrSel;
  } eaStrobe_t;

  function automatic modeClass_e classify(input logic [MODE_W-1:0] m);
    case (m)
      MD_IMM, MD_ACC, MD_REGX, MD_REGY:               classify = CL_VALUE;
      MD_ZPG, MD_ZPX, MD_ZPY, MD_ABS, MD_ABX, MD_ABY: classify = CL_DIRECT;
      MD_PREX, MD_POSY, MD_IND:                       classify = CL_POINTER;
      default:                                        classify = CL_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [MODE_W-1:0]    mode,
  input  logic                 memRdValid,
  output logic                 memReq,
  output logic                 done,
  output eaStrobe_t            stb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLO,
    ST_PHI,
    ST_DATA,
    ST_FIN
  } ctrlState_e;

  ctrlState_e stateQ, stateD;
  modeClass_e reqClass;

  assign reqClass = classify(mode);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        case (reqClass)
          CL_DIRECT:  stateD = ST_DATA;
          CL_POINTER: stateD = ST_PLO;
          default:    stateD = ST_FIN;
        endcase
      end
      ST_PLO:  if (memRdValid) stateD = ST_PHI;
      ST_PHI:  if (memRdValid) stateD = ST_DATA;
      ST_DATA: if (memRdValid) stateD = ST_FIN;
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stb.ldReq   = (stateQ == ST_IDLE) && reqValid;
    stb.ldPtrLo = (stateQ == ST_PLO)  && memRdValid;
    stb.ldPtrHi = (stateQ == ST_PHI)  && memRdValid;
    stb.ldData  = (stateQ == ST_DATA) && memRdValid;
    case (stateQ)
      ST_PLO:  stb.addrSel = AS_PTR_LO;
      ST_PHI:  stb.addrSel = AS_PTR_HI;
      default: stb.addrSel = AS_EA;
    endcase
  end

  assign memReq = (stateQ == ST_PLO) || (stateQ == ST_PHI) || (stateQ == ST_DATA);
  assign done   = (stateQ == ST_FIN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !memReq); // R9

endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eaStrobe_t            stb,
  input  logic [MODE_W-1:0]    mode,
  input  logic [DATA_W-1:0]    opLo,
  input  logic [DATA_W-1:0]    opHi,
  input  logic [DATA_W-1:0]    idxX,
  input  logic [DATA_W-1:0]    idxY,
  input  logic [DATA_W-1:0]    accIn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [2*DATA_W-1:0]  memAddr,
  output logic [2*DATA_W-1:0]  effAddr,
  output logic [DATA_W-1:0]    operand,
  output logic                 noAddr,
  output logic                 err
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] PAGE_ZERO = '0;

  logic [MODE_W-1:0] modeQ;
  logic [DATA_W-1:0] yQ, ptrLoQ, dataQ;
  logic [ADDR_W-1:0] eaQ, startAddr, ptrNext, idxAdd;
  logic              noAddrQ, errQ;
  logic [DATA_W-1:0] valueIn;
  modeClass_e        inClass;

  assign inClass = classify(mode);

  // First address: the operand address for direct modes, the pointer
  // location for pointer modes.
  always_comb begin
    case (mode)
      MD_ZPG:  startAddr = {PAGE_ZERO, opLo};
      MD_ZPX:  startAddr = {PAGE_ZERO, opLo + idxX};
      MD_ZPY:  startAddr = {PAGE_ZERO, opLo + idxY};
      MD_ABS:  startAddr = {opHi, opLo};
      MD_ABX:  startAddr = {opHi, opLo} + {PAGE_ZERO, idxX};
      MD_ABY:  startAddr = {opHi, opLo} + {PAGE_ZERO, idxY};
      MD_PREX: startAddr = {PAGE_ZERO, opLo + idxX};
      MD_POSY: startAddr = {PAGE_ZERO, opLo};
      MD_IND:  startAddr = {opHi, opLo};
      default: startAddr = '0;
    endcase
  end

  always_comb begin
    case (mode)
      MD_IMM:  valueIn = opLo;
      MD_ACC:  valueIn = accIn;
      MD_REGX: valueIn = idxX;
      MD_REGY: valueIn = idxY;
      default: valueIn = '0;
    endcase
  end

  // Second pointer byte: page-zero modes wrap in the low byte only.
  always_comb begin
    if (modeQ == MD_IND) ptrNext = eaQ + ADDR_W'(1);
    else                 ptrNext = {PAGE_ZERO, eaQ[DATA_W-1:0] + DATA_W'(1)};
  end

  assign idxAdd = (modeQ == MD_POSY) ? {PAGE_ZERO, yQ} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= '0;
      yQ      <= '0;
      ptrLoQ  <= '0;
      dataQ   <= '0;
      eaQ     <= '0;
      noAddrQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (stb.ldReq) begin
        modeQ   <= mode;
        yQ      <= idxY;
        eaQ     <= startAddr;
        dataQ   <= valueIn;
        noAddrQ <= (inClass == CL_VALUE) || (inClass == CL_BAD);
        errQ    <= (inClass == CL_BAD);
      end
      if (stb.ldPtrLo) ptrLoQ <= memRdData;
      if (stb.ldPtrHi) eaQ    <= {memRdData, ptrLoQ} + idxAdd;
      if (stb.ldData)  dataQ  <= memRdData;
    end
  end

  always_comb begin
    case (stb.addrSel)
      AS_PTR_LO: memAddr = eaQ;
      AS_PTR_HI: memAddr = ptrNext;
      default:   memAddr = eaQ;
    endcase
  end

  assign effAddr = eaQ;
  assign operand = dataQ;
  assign noAddr  = noAddrQ;
  assign err     = errQ;

  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldData && (modeQ == MD_ZPG || modeQ == MD_ZPX || modeQ == MD_ZPY))
      |-> (memAddr[ADDR_W-1:DATA_W] == '0)); // R2

  AST_PREX_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.ldPtrLo || stb.ldPtrHi) && modeQ == MD_PREX)
      |-> (memAddr[ADDR_W-1:DATA_W] == '0)); // R4

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [3:0]           mode,
  input  logic [DATA_W-1:0]    opLo,
  input  logic [DATA_W-1:0]    opHi,
  input  logic [DATA_W-1:0]    idxX,
  input  logic [DATA_W-1:0]    idxY,
  input  logic [DATA_W-1:0]    accIn,
  output logic                 memReq,
  output logic [2*DATA_W-1:0]  memAddr,
  input  logic                 memRdValid,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 done,
  output logic                 noAddr,
  output logic                 err,
  output logic [2*DATA_W-1:0]  effAddr,
  output logic [DATA_W-1:0]    operand
);

  eaStrobe_t stb;

  ea_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .mode       (mode),
    .memRdValid (memRdValid),
    .memReq     (memReq),
    .done       (done),
    .stb        (stb)
  );

  ea_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .mode      (mode),
    .opLo      (opLo),
    .opHi      (opHi),
    .idxX      (idxX),
    .idxY      (idxY),
    .accIn     (accIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .effAddr   (effAddr),
    .operand   (operand),
    .noAddr    (noAddr),
    .err       (err)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> (memReq && $stable(memAddr))); // R10

  AST_VALUE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (done && noAddr) |-> !$past(memReq)); // R1

endmodule

// File: tb/ea_resolver_tb.sv
module ea_resolver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WAIT   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opLo = '0, opHi = '0, idxX = '0, idxY = '0, accIn = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [7:0]  memRdData = '0;
  logic        done, noAddr, err;
  logic [15:0] effAddr;
  logic [7:0]  operand;

  int checks = 0;
  int failures = 0;
  int readCount = 0;
  int holdErrors = 0;
  bit finished = 0;
  int waitCnt = 0;
  logic [15:0] firstAddr;
  logic [7:0] memOv [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_resolver u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .opLo(opLo), .opHi(opHi), .idxX(idxX), .idxY(idxY), .accIn(accIn),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .done(done), .noAddr(noAddr), .err(err),
    .effAddr(effAddr), .operand(operand)
  );

  function automatic logic [7:0] memRead(input logic [15:0] a);
    if (memOv.exists(int'(a))) return memOv[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // Memory model with a fixed wait; also watches that the request holds.
  always @(posedge clk) begin
    if (memReq && !memRdValid) begin
      if (waitCnt == 0) firstAddr <= memAddr;
      else if (memAddr != firstAddr) holdErrors <= holdErrors + 1;
      if (waitCnt == MEM_WAIT) begin
        memRdValid <= 1'b1;
        memRdData  <= memRead(memAddr);
        waitCnt    <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      memRdValid <= 1'b0;
    end
    if (memReq && memRdValid) readCount <= readCount + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] acc,
                       input logic [15:0] expEa, input logic [7:0] expOp,
                       input bit expNoAddr, input bit expErr, input int expReads,
                       input string tag);
    int n;
    @(negedge clk);
    mode = m; opLo = lo; opHi = hi; idxX = x; idxY = y; accIn = acc;
    readCount = 0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk(done == 1'b1, tag, "done", 32'(done), 1);
    chk(noAddr == expNoAddr, tag, "noAddr", 32'(noAddr), 32'(expNoAddr));
    chk(err == expErr, tag, "err", 32'(err), 32'(expErr));
    chk(readCount == expReads, tag, "reads", 32'(readCount), 32'(expReads));
    chk(operand == expOp, tag, "operand", 32'(operand), 32'(expOp));
    if (!expNoAddr) chk(effAddr == expEa, tag, "effAddr", 32'(effAddr), 32'(expEa));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", 32'(done), 0);
  endtask

  task automatic testReset();
    chk(done == 1'b0, "R11", "done at reset", 32'(done), 0);
    chk(memReq == 1'b0, "R11", "memReq at reset", 32'(memReq), 0);
  endtask

  task automatic testValueModes();
    runOp(4'd0,  8'h3C, 8'h77, 8'h01, 8'h02, 8'h03, 16'h0, 8'h3C, 1, 0, 0, "R1 imm");
    runOp(4'd10, 8'h3C, 8'h77, 8'h01, 8'h02, 8'h81, 16'h0, 8'h81, 1, 0, 0, "R1 acc");
    runOp(4'd11, 8'h3C, 8'h77, 8'h7E, 8'h02, 8'h81, 16'h0, 8'h7E, 1, 0, 0, "R1 regx");
    runOp(4'd12, 8'h3C, 8'h77, 8'h7E, 8'h00, 8'h81, 16'h0, 8'h00, 1, 0, 0, "R1 regy");
  endtask

  task automatic testZeroPage();
    runOp(4'd1, 8'h42, 8'h99, 8'h00, 8'h00, 8'h00, 16'h0042, memRead(16'h0042), 0, 0, 1, "R2 R7 zpg");
    runOp(4'd2, 8'hF0, 8'h99, 8'h20, 8'h00, 8'h00, 16'h0010, memRead(16'h0010), 0, 0, 1, "R2 zpx wrap");
    runOp(4'd3, 8'hFF, 8'h99, 8'h00, 8'h01, 8'h00, 16'h0000, memRead(16'h0000), 0, 0, 1, "R2 zpy wrap");
  endtask

  task automatic testAbsolute();
    runOp(4'd4, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 16'h1234, memRead(16'h1234), 0, 0, 1, "R3 abs");
    runOp(4'd5, 8'h80, 8'h12, 8'hFF, 8'h00, 8'h00, 16'h137F, memRead(16'h137F), 0, 0, 1, "R3 abx carry");
    runOp(4'd6, 8'hF0, 8'hFF, 8'h00, 8'h20, 8'h00, 16'h0010, memRead(16'h0010), 0, 0, 1, "R3 aby rollover");
  endtask

  task automatic testPreIndexed();
    memOv.delete();
    memOv[16'h0015] = 8'hCD; memOv[16'h0016] = 8'hAB;
    runOp(4'd7, 8'h10, 8'h00, 8'h05, 8'h00, 8'h00, 16'hABCD, memRead(16'hABCD), 0, 0, 3, "R4 R7 prex");
    memOv[16'h00FF] = 8'h34; memOv[16'h0000] = 8'h12; memOv[16'h0100] = 8'h99;
    runOp(4'd7, 8'hFE, 8'h00, 8'h01, 8'h00, 8'h00, 16'h1234, memRead(16'h1234), 0, 0, 3, "R4 ptr at FF");
  endtask

  task automatic testPostIndexed();
    memOv.delete();
    memOv[16'h0020] = 8'hF0; memOv[16'h0021] = 8'h12;
    runOp(4'd8, 8'h20, 8'h00, 8'h00, 8'h20, 8'h00, 16'h1310, memRead(16'h1310), 0, 0, 3, "R5 posy carry");
    memOv[16'h00FF] = 8'hFF; memOv[16'h0000] = 8'hFF; memOv[16'h0100] = 8'h00;
    runOp(4'd8, 8'hFF, 8'h00, 8'h00, 8'h02, 8'h00, 16'h0001, memRead(16'h0001), 0, 0, 3, "R5 wrap both");
  endtask

  task automatic testAbsIndirect();
    memOv.delete();
    memOv[16'h30FF] = 8'h78; memOv[16'h3100] = 8'h56; memOv[16'h3000] = 8'h11;
    runOp(4'd9, 8'hFF, 8'h30, 8'h00, 8'h00, 8'h00, 16'h5678, memRead(16'h5678), 0, 0, 3, "R6 page carry");
    memOv.delete();
  endtask

  task automatic testBadModes();
    for (int c = 13; c <= 15; c++)
      runOp(4'(c), 8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00, 1, 1, 0, "R8 unused code");
  endtask

  task automatic testIgnoreBusy();
    int n;
    int doneCount;
    memOv.delete();
    memOv[16'h30FF] = 8'h78; memOv[16'h3100] = 8'h56;
    @(negedge clk);
    mode = 4'd9; opLo = 8'hFF; opHi = 8'h30; readCount = 0;
    reqValid = 1'b1;
    @(negedge clk);
    mode = 4'd0; opLo = 8'h55;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    reqValid = 1'b0;
    chk(noAddr == 1'b0, "R9", "busy request ignored (noAddr)", 32'(noAddr), 0);
    chk(effAddr == 16'h5678, "R9", "busy request ignored (effAddr)", 32'(effAddr), 32'h5678);
    chk(readCount == 3, "R9", "reads while busy", 32'(readCount), 3);
    doneCount = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) doneCount++;
    end
    chk(doneCount == 0, "R9", "extra done pulses", 32'(doneCount), 0);
    chk(holdErrors == 0, "R10", "address changed while waiting", 32'(holdErrors), 0);
    memOv.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testValueModes();
    testZeroPage();
    testAbsolute();
    testPreIndexed();
    testPostIndexed();
    testAbsIndirect();
    testBadModes();
    testIgnoreBusy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule